// File: doc/BRIEF.md
# Commutation-Gated Channel Control Staging

This block sits between the control registers of a PWM timer and its output stage. It keeps, for each output channel, the enable pair, the polarity pair and the output-mode field that the output stage acts on. For channels that drive a complementary pair of pins, the block can either let a written value act at once, or hold it in a shadow copy until a commutation event. A commutation event is a software strobe or, when selected, a rising edge on a trigger input. All complementary channels then switch together in the same clock cycle. This is the mechanism used to change a motor drive pattern on an exact instant.

Channels without complementary outputs never use the shadow stage: their written values always act at once. A small configuration register inside the block holds the staging-enable bit and the trigger-select bit. Both clear to zero on reset, so after reset every write acts at once.

Top module: `ccp_commute_preload`

## Requirements
- R1: After reset, every bit of `act_en`, `act_pol` and `act_mode` is 0, staging is off and the trigger source is deselected.
- R2: While staging is off, a write to a complementary channel (its `ch_we` bit high for one cycle) appears on that channel's active outputs after the clock edge that takes the write.
- R3: While staging is on, a write to a complementary channel changes none of its active outputs until a commutation event occurs.
- R4: While staging is on, `com_sw` high in a cycle copies every complementary channel's shadow value to its active outputs at that clock edge.
- R5: While staging is on and the trigger is selected, a 0-to-1 change of `trig_in` seen at clock edge k copies the shadow values to the active outputs at edge k+1, so nothing changes at edge k itself.
- R6: While the trigger is deselected, edges on `trig_in` never move shadow values to the active outputs.
- R7: A write and a commutation event in the same cycle put the newly written value on the active outputs.
- R8: The plain channels (index N_COMP and above) take every write at the next edge whatever the staging state. Their complementary enable and complementary polarity outputs are always 0.
- R9: A `trig_in` held high, or a falling edge, causes no transfer.
- R10: `cfg_we` loads `cfg_preload_in` and `cfg_trig_sel_in` at the clock edge. Turning staging off makes the active outputs follow the shadow values from the following edge on.
- R11: Bit layout: for channel i, `act_en[2i]` is the main-output enable and `act_en[2i+1]` the complementary enable. `act_pol` follows the same layout. `act_mode[MODE_W*i +: MODE_W]` is the mode field. On the write side, `wr_en[0]`/`wr_pol[0]` are the main bits and `[1]` the complementary bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the configuration bits |
| cfg_preload_in | input | 1 | Staging enable value to load |
| cfg_trig_sel_in | input | 1 | Trigger-as-commutation-source value to load |
| ch_we | input | 4 | Per-channel write strobe |
| wr_en | input | 2 | Write data: enable pair |
| wr_pol | input | 2 | Write data: polarity pair |
| wr_mode | input | 3 | Write data: output mode |
| com_sw | input | 1 | Software commutation strobe |
| trig_in | input | 1 | Trigger input, rising edge may commute |
| act_en | output | 8 | Active enable pairs, two bits per channel |
| act_pol | output | 8 | Active polarity pairs, two bits per channel |
| act_mode | output | 12 | Active mode fields, three bits per channel |

## Verification
A shadow copy that loaded the wrong value stays hidden until the next commutation. It then shows as a wrong pattern on every complementary channel at once, one edge after the strobe, or two edges after a trigger rise. A wrong staging or trigger-select bit shows as outputs that change on a plain write, or as outputs that fail to change on a strobe. A broken edge detector transfers one cycle early or late, or transfers on a held-high or falling trigger. The bench compares all outputs every cycle, so each of these faults is reported within a cycle of the event that exposes it.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    // staging configuration held inside the block
    typedef struct packed {
        logic preload;
        logic trig_sel;
    } ccp_cfg_t;

    // two-stage trigger history
    typedef struct packed {
        logic sync;
        logic prev;
    } ccp_trig_t;

    localparam int CCP_PAIR_W = 2;

endpackage

// File: rtl/ccp_cfg_reg.sv
module ccp_cfg_reg
    import ccp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic preload_in,
    input  logic trig_sel_in,
    output logic preload,
    output logic trig_sel
);

    ccp_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.preload  = preload_in;
            cfg_d.trig_sel = trig_sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign preload  = cfg_q.preload;
    assign trig_sel = cfg_q.trig_sel;

endmodule

// File: rtl/ccp_trig_edge.sv
module ccp_trig_edge
    import ccp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise
);

    ccp_trig_t trg_d, trg_q;

    always_comb begin
        trg_d      = trg_q;
        trg_d.sync = trig_in;
        trg_d.prev = trg_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trg_q <= '0;
        else        trg_q <= trg_d;
    end

    // high for the one cycle after the registered copy went 0 -> 1
    assign rise = trg_q.sync & ~trg_q.prev;

endmodule

// File: rtl/ccp_chan_slot.sv
module ccp_chan_slot
    import ccp_pkg::*;
#(
    parameter int MODE_W   = 3,
    parameter bit HAS_COMP = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CCP_PAIR_W-1:0] wr_en,
    input  logic [CCP_PAIR_W-1:0] wr_pol,
    input  logic [MODE_W-1:0]     wr_mode,
    input  logic                  preload,
    input  logic                  commute,
    output logic [CCP_PAIR_W-1:0] act_en,
    output logic [CCP_PAIR_W-1:0] act_pol,
    output logic [MODE_W-1:0]     act_mode
);

    // plain channels keep only the main-output bit of each pair
    localparam logic [CCP_PAIR_W-1:0] PAIR_MASK = HAS_COMP ? 2'b11 : 2'b01;

    typedef struct packed {
        logic [CCP_PAIR_W-1:0] en;
        logic [CCP_PAIR_W-1:0] pol;
        logic [MODE_W-1:0]     mode;
    } bits_t;

    typedef struct packed {
        bits_t shadow;
        bits_t active;
    } slot_t;

    slot_t st_d, st_q;
    logic  pass_through;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.shadow.en   = wr_en & PAIR_MASK;
            st_d.shadow.pol  = wr_pol & PAIR_MASK;
            st_d.shadow.mode = wr_mode;
        end
        pass_through = !HAS_COMP || !preload || commute;
        if (pass_through) st_d.active = st_d.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_en   = st_q.active.en;
    assign act_pol  = st_q.active.pol;
    assign act_mode = st_q.active.mode;

endmodule

// File: rtl/ccp_commute_preload.sv
module ccp_commute_preload
    import ccp_pkg::*;
#(
    parameter int N_COMP  = 3,
    parameter int N_PLAIN = 1,
    parameter int MODE_W  = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic                                 cfg_preload_in,
    input  logic                                 cfg_trig_sel_in,
    input  logic [N_COMP+N_PLAIN-1:0]            ch_we,
    input  logic [1:0]                           wr_en,
    input  logic [1:0]                           wr_pol,
    input  logic [MODE_W-1:0]                    wr_mode,
    input  logic                                 com_sw,
    input  logic                                 trig_in,
    output logic [2*(N_COMP+N_PLAIN)-1:0]        act_en,
    output logic [2*(N_COMP+N_PLAIN)-1:0]        act_pol,
    output logic [MODE_W*(N_COMP+N_PLAIN)-1:0]   act_mode
);

    localparam int NCH = N_COMP + N_PLAIN;

    logic cfg_preload;
    logic cfg_trig_sel;
    logic trig_rise;
    logic commute;

    ccp_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .preload_in  (cfg_preload_in),
        .trig_sel_in (cfg_trig_sel_in),
        .preload     (cfg_preload),
        .trig_sel    (cfg_trig_sel)
    );

    ccp_trig_edge u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .rise    (trig_rise)
    );

    // commutation sources; gated by the staging bit inside each slot
    assign commute = com_sw | (cfg_trig_sel & trig_rise);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ccp_chan_slot #(
            .MODE_W   (MODE_W),
            .HAS_COMP (g < N_COMP)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (ch_we[g]),
            .wr_en    (wr_en),
            .wr_pol   (wr_pol),
            .wr_mode  (wr_mode),
            .preload  (cfg_preload),
            .commute  (commute),
            .act_en   (act_en[2*g +: 2]),
            .act_pol  (act_pol[2*g +: 2]),
            .act_mode (act_mode[MODE_W*g +: MODE_W])
        );
    end

endmodule

// File: rtl/ccp_commute_preload_chk.sv
module ccp_commute_preload_chk #(
    parameter int N_COMP  = 3,
    parameter int N_PLAIN = 1,
    parameter int MODE_W  = 3
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [N_COMP+N_PLAIN-1:0]          ch_we,
    input logic [1:0]                         wr_en,
    input logic [1:0]                         wr_pol,
    input logic [MODE_W-1:0]                  wr_mode,
    input logic                               com_sw,
    input logic                               cfg_preload,
    input logic                               cfg_trig_sel,
    input logic                               trig_rise,
    input logic [2*(N_COMP+N_PLAIN)-1:0]      act_en,
    input logic [2*(N_COMP+N_PLAIN)-1:0]      act_pol,
    input logic [MODE_W*(N_COMP+N_PLAIN)-1:0] act_mode
);

    localparam int NCH = N_COMP + N_PLAIN;

    logic just_reset_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) just_reset_q <= 1'b1;
        else        just_reset_q <= 1'b0;
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        just_reset_q |-> (act_en == '0 && act_pol == '0 && act_mode == '0 &&
                          !cfg_preload && !cfg_trig_sel));

    a_r3_hold_without_commute: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_preload && !com_sw && !(cfg_trig_sel && trig_rise)) |=>
        ($stable(act_en[2*N_COMP-1:0]) && $stable(act_pol[2*N_COMP-1:0]) &&
         $stable(act_mode[MODE_W*N_COMP-1:0])));

    a_r6_trigger_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_preload && !cfg_trig_sel && !com_sw) |=>
        ($stable(act_en[2*N_COMP-1:0]) && $stable(act_pol[2*N_COMP-1:0])));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        if (g < N_COMP) begin : g_comp
            a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_preload && ch_we[g]) |=>
                (act_en[2*g +: 2] == $past(wr_en) && act_pol[2*g +: 2] == $past(wr_pol) &&
                 act_mode[MODE_W*g +: MODE_W] == $past(wr_mode)));

            a_r7_write_with_commute: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_preload && com_sw && ch_we[g]) |=>
                (act_en[2*g +: 2] == $past(wr_en) && act_pol[2*g +: 2] == $past(wr_pol) &&
                 act_mode[MODE_W*g +: MODE_W] == $past(wr_mode)));
        end else begin : g_plain
            a_r8_plain_immediate: assert property (@(posedge clk) disable iff (!rst_n)
                ch_we[g] |=>
                (act_en[2*g] == $past(wr_en[0]) && act_pol[2*g] == $past(wr_pol[0]) &&
                 act_mode[MODE_W*g +: MODE_W] == $past(wr_mode)));

            a_r8_plain_no_comp: assert property (@(posedge clk) disable iff (!rst_n)
                (act_en[2*g+1] == 1'b0 && act_pol[2*g+1] == 1'b0));
        end
    end

endmodule

bind ccp_commute_preload ccp_commute_preload_chk #(
    .N_COMP  (N_COMP),
    .N_PLAIN (N_PLAIN),
    .MODE_W  (MODE_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_we        (ch_we),
    .wr_en        (wr_en),
    .wr_pol       (wr_pol),
    .wr_mode      (wr_mode),
    .com_sw       (com_sw),
    .cfg_preload  (cfg_preload),
    .cfg_trig_sel (cfg_trig_sel),
    .trig_rise    (trig_rise),
    .act_en       (act_en),
    .act_pol      (act_pol),
    .act_mode     (act_mode)
);

// File: tb/test_ccp_commute_preload.sv
module test_ccp_commute_preload;

    localparam int N_COMP  = 3;
    localparam int N_PLAIN = 1;
    localparam int MODE_W  = 3;
    localparam int NCH     = N_COMP + N_PLAIN;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 20 ns period

    logic                  rst_n = 1'b0;
    logic                  cfg_we = 1'b0, cfg_preload_in = 1'b0, cfg_trig_sel_in = 1'b0;
    logic [NCH-1:0]        ch_we = '0;
    logic [1:0]            wr_en = '0, wr_pol = '0;
    logic [MODE_W-1:0]     wr_mode = '0;
    logic                  com_sw = 1'b0, trig_in = 1'b0;
    logic [2*NCH-1:0]      act_en, act_pol;
    logic [MODE_W*NCH-1:0] act_mode;

    ccp_commute_preload #(.N_COMP(N_COMP), .N_PLAIN(N_PLAIN), .MODE_W(MODE_W)) i_ccp_commute_preload (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_preload_in(cfg_preload_in),
        .cfg_trig_sel_in(cfg_trig_sel_in), .ch_we(ch_we), .wr_en(wr_en), .wr_pol(wr_pol),
        .wr_mode(wr_mode), .com_sw(com_sw), .trig_in(trig_in),
        .act_en(act_en), .act_pol(act_pol), .act_mode(act_mode)
    );

    // reference state derived from the requirements
    logic [1:0]        sh_en [NCH], sh_pol [NCH], ac_en [NCH], ac_pol [NCH];
    logic [MODE_W-1:0] sh_mode [NCH], ac_mode [NCH];
    logic              m_pre, m_sel, m_ts, m_ts2;
    int total = 0, bad = 0;
    bit done = 1'b0;

    function automatic void model_reset();
        for (int i = 0; i < NCH; i++) begin
            sh_en[i] = '0; sh_pol[i] = '0; sh_mode[i] = '0;
            ac_en[i] = '0; ac_pol[i] = '0; ac_mode[i] = '0;
        end
        m_pre = 1'b0; m_sel = 1'b0; m_ts = 1'b0; m_ts2 = 1'b0;
    endfunction

    // one clock edge of the expected behaviour, using the inputs held at that edge
    function automatic void model_tick();
        logic rise_seen, comm;
        rise_seen = m_ts & ~m_ts2;                       // R5: registered edge, acts one edge later
        comm = m_pre && (com_sw || (m_sel && rise_seen)); // R4 R6 R9
        for (int i = 0; i < NCH; i++) begin
            if (ch_we[i]) begin
                sh_en[i]   = (i < N_COMP) ? wr_en  : {1'b0, wr_en[0]};   // R8
                sh_pol[i]  = (i < N_COMP) ? wr_pol : {1'b0, wr_pol[0]};
                sh_mode[i] = wr_mode;
            end
            if (i >= N_COMP || !m_pre || comm) begin   // R2 R3 R7 R8
                ac_en[i] = sh_en[i]; ac_pol[i] = sh_pol[i]; ac_mode[i] = sh_mode[i];
            end
        end
        if (cfg_we) begin m_pre = cfg_preload_in; m_sel = cfg_trig_sel_in; end   // R10
        m_ts2 = m_ts;
        m_ts  = trig_in;
    endfunction

    task automatic check_now(input string tag);
        logic [2*NCH-1:0]      e_en, e_pol;
        logic [MODE_W*NCH-1:0] e_mode;
        for (int i = 0; i < NCH; i++) begin   // R11 layout
            e_en[2*i +: 2] = ac_en[i];
            e_pol[2*i +: 2] = ac_pol[i];
            e_mode[MODE_W*i +: MODE_W] = ac_mode[i];
        end
        total++;
        if (act_en !== e_en || act_pol !== e_pol || act_mode !== e_mode) begin
            bad++;
            $display("FAIL %s: en=%h pol=%h mode=%h expected en=%h pol=%h mode=%h",
                     tag, act_en, act_pol, act_mode, e_en, e_pol, e_mode);
        end
    endtask

    // called at a negedge with inputs already set
    task automatic step(input string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        check_now(tag);
        ch_we = '0; com_sw = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wr(input int ch, input logic [1:0] en, input logic [1:0] pol, input logic [MODE_W-1:0] md);
        ch_we[ch] = 1'b1; wr_en = en; wr_pol = pol; wr_mode = md;
    endtask

    task automatic cfg(input logic pre, input logic sel);
        cfg_we = 1'b1; cfg_preload_in = pre; cfg_trig_sel_in = sel;
    endtask

    initial begin
        model_reset();
        void'($urandom(32'h0C0A_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_now("R1 reset state");

        wr(0, 2'b11, 2'b10, 3'd6);  step("R2 immediate write ch0");
        wr(3, 2'b11, 2'b11, 3'd5);  step("R8 plain comp bits forced zero");
        cfg(1'b1, 1'b0);            step("R10 staging on");
        wr(1, 2'b01, 2'b01, 3'd3);  step("R3 held in shadow");
        step("R3 still held");
        com_sw = 1'b1;              step("R4 software commutation");
        wr(2, 2'b10, 2'b11, 3'd7); com_sw = 1'b1; step("R7 write and commute same cycle");
        wr(0, 2'b01, 2'b00, 3'd2); trig_in = 1'b1; step("R6 trigger rise deselected");
        step("R6 no transfer");
        step("R6 no transfer later");
        trig_in = 1'b0; cfg(1'b1, 1'b1); step("R10 select trigger");
        step("R9 idle");
        trig_in = 1'b1;             step("R5 not yet at edge of detection");
        step("R5 transfer one edge later");
        wr(1, 2'b10, 2'b10, 3'd1);  step("R9 held high no transfer");
        step("R9 held high still none");
        trig_in = 1'b0;             step("R9 falling edge no transfer");
        step("R9 low no transfer");
        wr(3, 2'b01, 2'b01, 3'd4);  step("R8 plain immediate with staging on");
        cfg(1'b0, 1'b1);            step("R10 staging off, one edge");
        step("R10 active follows shadow");

        for (int n = 0; n < 4000; n++) begin
            ch_we   = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
            wr_en   = 2'($urandom);
            wr_pol  = 2'($urandom);
            wr_mode = MODE_W'($urandom);
            com_sw  = (($urandom % 8) == 0);
            if (($urandom % 3) == 0) trig_in = ~trig_in;
            if (($urandom % 40) == 0) cfg(1'($urandom), 1'($urandom));
            step("random R2/R3/R4/R5/R7/R8 mix");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule